// File: doc/BRIEF.md
# Conditional Branch-to-Link Evaluator

This block resolves a conditional branch whose target comes from the link register. On each execute strobe it takes the instruction's branch-options field, the condition-bit selector, the link flag and the current instruction address. It also takes the live condition, count and link register values. From these it works out three things: whether the branch is taken, the next instruction address, and the new count and link register values. All three results land in output registers on the same clock edge.

The count register may be decremented and then tested against zero. In 32-bit mode only its low 32 bits are tested; in 64-bit mode every bit is tested. One selected condition bit is compared with a chosen polarity. Either test can be bypassed by a bit of the options field. The branch is taken only when both tests pass. Fields use big-endian numbering: bit 0 of the 5-bit options field is its most significant bit (`bo[4]`).

The interface is a plain strobe with no back-pressure. `exec` is accepted on every clock where it is high, and the block never stalls. The results are visible one cycle after the strobe and are held until the next strobe.

Top module: `brl_eval`

## Requirements
- R1: After a synchronous reset (`rst` high), `nia_q`, `ctr_q` and `lr_q` are all zero.
- R2: While `exec` is low, `nia_q`, `ctr_q` and `lr_q` keep their values.
- R3: On a strobe with `bo[2]` (options bit 2) low, `ctr_q` becomes `ctr_in - 1`. With `bo[2]` high, `ctr_q` becomes `ctr_in` unchanged.
- R4: The count test passes when `bo[2]` is high. Otherwise it passes when (the tested bits of the possibly decremented count are nonzero) XOR `bo[1]` (options bit 3).
- R5: With `wide_mode` high all 64 count bits are tested. With it low, only count bits 31..0 (big-endian bits 32..63) are tested.
- R6: The condition test passes when `bo[4]` (options bit 0) is high. Otherwise it passes when `cr[31-bi]` (big-endian condition bit `bi+32`) equals `bo[3]` (options bit 1).
- R7: When both tests pass, `nia_q` becomes `lr_in` with bits 1..0 cleared. Otherwise it becomes `cia + 4`.
- R8: With `lk` high, `lr_q` becomes `cia + 4` whether the branch is taken or not. With `lk` low, `lr_q` becomes `lr_in`.
- R9: The branch target always comes from `lr_in`, the link value before the strobe, even when `lk` is high.
- R10: The hint field `bh` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | Execute strobe; results are committed on this edge |
| bo | input | 5 | Branch-options field, `bo[4]` is big-endian bit 0 |
| bi | input | 5 | Condition bit selector |
| bh | input | 2 | Branch hint, ignored |
| lk | input | 1 | Link write enable |
| wide_mode | input | 1 | 1 = 64-bit count test, 0 = 32-bit count test |
| cia | input | 64 | Current instruction address |
| cr | input | 32 | Condition register |
| ctr_in | input | 64 | Current count register |
| lr_in | input | 64 | Current link register |
| nia_q | output | 64 | Next instruction address |
| ctr_q | output | 64 | Updated count register |
| lr_q | output | 64 | Updated link register |

## Verification
The assertions check the following on every cycle:
- outputs hold between strobes;
- the decrement-or-keep rule for the count;
- the link write and the link pass-through;
- a failed condition test always falls through to `cia + 4`;
- a branch with both tests bypassed always goes to the aligned old link value;
- every next address is either the fall-through or the aligned target.

Some behaviour needs the bench's scenarios and its reference model. This covers the count test at the 32/64-bit boundary (a count whose low word reaches zero while the upper word does not) and the inversion by `bo[1]`. It also covers the condition-bit selection at both ends of `bi`, the use of the old link value when `lk` is set, and the insensitivity to `bh`.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int BO_W = 5;
  localparam int BI_W = 5;
  localparam int BH_W = 2;

  // Branch-options field seen through big-endian bit names.
  typedef struct packed {
    logic cond_bypass;   // options bit 0
    logic cond_want;     // options bit 1
    logic cnt_bypass;    // options bit 2, also suppresses the decrement
    logic cnt_invert;    // options bit 3
    logic spare;         // options bit 4
  } bo_t;

  function automatic bo_t decode_bo(input logic [BO_W-1:0] raw);
    bo_t f;
    f.cond_bypass = raw[BO_W-1];
    f.cond_want   = raw[BO_W-2];
    f.cnt_bypass  = raw[BO_W-3];
    f.cnt_invert  = raw[BO_W-4];
    f.spare       = raw[BO_W-5];
    return f;
  endfunction
endpackage

// File: rtl/brl_count_unit.sv
module brl_count_unit #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic [XLEN-1:0] ctr_in,
  input  logic            no_dec,
  input  logic            invert,
  input  logic            wide_mode,
  output logic [XLEN-1:0] ctr_next,
  output logic            cnt_ok
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic nz_wide;
  logic nz_narrow;
  logic nz_sel;

  always_comb begin
    ctr_next = no_dec ? ctr_in : (ctr_in - ONE);
  end

  assign nz_wide = |ctr_next;

  generate
    if (NARROW_W >= XLEN) begin : g_same
      assign nz_narrow = nz_wide;
      logic unused_mode;
      assign unused_mode = wide_mode;
    end else begin : g_split
      assign nz_narrow = |ctr_next[NARROW_W-1:0];
    end
  endgenerate

  generate
    if (NARROW_W >= XLEN) begin : g_sel_same
      assign nz_sel = nz_wide;
    end else begin : g_sel_mux
      assign nz_sel = wide_mode ? nz_wide : nz_narrow;
    end
  endgenerate

  assign cnt_ok = no_dec | (nz_sel ^ invert);
endmodule

// File: rtl/brl_cond_unit.sv
module brl_cond_unit #(
  parameter int CRW  = 32,
  parameter int SELW = 5
) (
  input  logic [CRW-1:0]  cr,
  input  logic [SELW-1:0] sel,
  input  logic            bypass,
  input  logic            want,
  output logic            cond_ok
);
  // Big-endian selection: selector 0 picks the most significant bit.
  logic [CRW-1:0] cr_rev;
  logic           picked;

  genvar g;
  generate
    for (g = 0; g < CRW; g++) begin : g_rev
      assign cr_rev[g] = cr[CRW-1-g];
    end
  endgenerate

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < CRW; k++) begin
      if (SELW'(k) == sel) picked = cr_rev[k];
    end
  end

  assign cond_ok = bypass | (picked == want);
endmodule

// File: rtl/brl_target_unit.sv
module brl_target_unit #(
  parameter int XLEN       = 64,
  parameter int STEP_BYTES = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] lr_in,
  input  logic            lk,
  input  logic            take,
  output logic [XLEN-1:0] nia_next,
  output logic [XLEN-1:0] lr_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] tgt_addr;

  assign seq_addr = cia + STEP;
  assign tgt_addr = {lr_in[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_comb begin
    nia_next = take ? tgt_addr : seq_addr;
    lr_next  = lk ? seq_addr : lr_in;
  end
endmodule

// File: rtl/brl_eval.sv
module brl_eval #(
  parameter int XLEN = 64,
  parameter int CRW  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      exec,
  input  logic [brl_pkg::BO_W-1:0]  bo,
  input  logic [brl_pkg::BI_W-1:0]  bi,
  input  logic [brl_pkg::BH_W-1:0]  bh,
  input  logic                      lk,
  input  logic                      wide_mode,
  input  logic [XLEN-1:0]           cia,
  input  logic [CRW-1:0]            cr,
  input  logic [XLEN-1:0]           ctr_in,
  input  logic [XLEN-1:0]           lr_in,
  output logic [XLEN-1:0]           nia_q,
  output logic [XLEN-1:0]           ctr_q,
  output logic [XLEN-1:0]           lr_q
);
  import brl_pkg::*;

  localparam int NARROW_W = XLEN / 2;

  bo_t             opt;
  logic            cnt_ok;
  logic            cond_ok;
  logic            take;
  logic [XLEN-1:0] ctr_next;
  logic [XLEN-1:0] nia_next;
  logic [XLEN-1:0] lr_next;
  logic            unused_fields;

  assign opt = decode_bo(bo);
  assign unused_fields = ^{bh, opt.spare};

  brl_count_unit #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_cnt (
    .ctr_in    (ctr_in),
    .no_dec    (opt.cnt_bypass),
    .invert    (opt.cnt_invert),
    .wide_mode (wide_mode),
    .ctr_next  (ctr_next),
    .cnt_ok    (cnt_ok)
  );

  brl_cond_unit #(.CRW(CRW), .SELW(BI_W)) u_cond (
    .cr      (cr),
    .sel     (bi),
    .bypass  (opt.cond_bypass),
    .want    (opt.cond_want),
    .cond_ok (cond_ok)
  );

  assign take = cnt_ok & cond_ok;

  brl_target_unit #(.XLEN(XLEN), .STEP_BYTES(4), .ALIGN_BITS(2)) u_tgt (
    .cia      (cia),
    .lr_in    (lr_in),
    .lk       (lk),
    .take     (take),
    .nia_next (nia_next),
    .lr_next  (lr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nia_q <= '0;
      ctr_q <= '0;
      lr_q  <= '0;
    end else if (exec) begin
      nia_q <= nia_next;
      ctr_q <= ctr_next;
      lr_q  <= lr_next;
    end
  end
endmodule

// File: rtl/brl_eval_chk.sv
module brl_eval_chk #(
  parameter int XLEN = 64,
  parameter int CRW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exec,
  input logic [4:0]      bo,
  input logic [4:0]      bi,
  input logic            lk,
  input logic [XLEN-1:0] cia,
  input logic [CRW-1:0]  cr,
  input logic [XLEN-1:0] ctr_in,
  input logic [XLEN-1:0] lr_in,
  input logic [XLEN-1:0] nia_q,
  input logic [XLEN-1:0] ctr_q,
  input logic [XLEN-1:0] lr_q
);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);
  localparam logic [XLEN-1:0] ONE  = XLEN'(1);
  localparam logic [XLEN-1:0] ALN  = ~XLEN'(3);

  logic sel_bit;
  assign sel_bit = cr[(CRW-1) - int'(bi)];

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec |=> ($stable(nia_q) && $stable(ctr_q) && $stable(lr_q)));

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && !bo[2]) |=> (ctr_q == $past(ctr_in) - ONE));

  // R3
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && bo[2]) |=> (ctr_q == $past(ctr_in)));

  // R8
  link_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && lk) |=> (lr_q == $past(cia) + FOUR));

  // R8
  nolink_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && !lk) |=> (lr_q == $past(lr_in)));

  // R6
  cond_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && !bo[4] && (sel_bit != bo[3])) |=> (nia_q == $past(cia) + FOUR));

  // R4
  bypass_take_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && bo[2] && bo[4]) |=> (nia_q == ($past(lr_in) & ALN)));

  // R7
  nia_form_chk: assert property (@(posedge clk) disable iff (rst)
    exec |=> ((nia_q == $past(cia) + FOUR) || (nia_q == ($past(lr_in) & ALN))));
endmodule

bind brl_eval brl_eval_chk #(.XLEN(XLEN), .CRW(CRW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .exec   (exec),
  .bo     (bo),
  .bi     (bi),
  .lk     (lk),
  .cia    (cia),
  .cr     (cr),
  .ctr_in (ctr_in),
  .lr_in  (lr_in),
  .nia_q  (nia_q),
  .ctr_q  (ctr_q),
  .lr_q   (lr_q)
);

// File: tb/sim_brl_eval.sv
`timescale 1ns/1ps
module sim_brl_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec = 1'b0;
  logic [4:0]  bo = '0;
  logic [4:0]  bi = '0;
  logic [1:0]  bh = '0;
  logic        lk = 1'b0;
  logic        wide_mode = 1'b1;
  logic [63:0] cia = '0;
  logic [31:0] cr = '0;
  logic [63:0] ctr_in = '0;
  logic [63:0] lr_in = '0;
  logic [63:0] nia_q, ctr_q, lr_q;

  logic [63:0] e_nia = '0, e_ctr = '0, e_lr = '0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brl_eval u0 (
    .clk(clk), .rst(rst), .exec(exec), .bo(bo), .bi(bi), .bh(bh), .lk(lk),
    .wide_mode(wide_mode), .cia(cia), .cr(cr), .ctr_in(ctr_in), .lr_in(lr_in),
    .nia_q(nia_q), .ctr_q(ctr_q), .lr_q(lr_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit opt(input logic [4:0] f, input int n);
    return f[4-n];
  endfunction

  // Behavioural reference: computes the next expected register state.
  task automatic model();
    logic [63:0] cnt;
    logic [63:0] crw;
    bit nz, c_ok, k_ok;
    int idx;
    if (!exec) return;
    cnt = ctr_in;
    if (!opt(bo, 2)) cnt = ctr_in - 64'd1;
    nz = 0;
    for (int b = (wide_mode ? 0 : 32); b < 64; b++) if (cnt[63-b]) nz = 1;
    c_ok = opt(bo, 2) || (nz != opt(bo, 3));
    crw = {32'h0, cr};
    idx = int'(bi) + 32;
    k_ok = opt(bo, 0) || (crw[63-idx] != !opt(bo, 1));
    e_ctr = cnt;
    e_nia = (c_ok && k_ok) ? {lr_in[63:2], 2'b00} : cia + 64'd4;
    e_lr  = lk ? cia + 64'd4 : lr_in;
  endtask

  task automatic step(input logic e, input logic [4:0] o, input logic [4:0] s,
                      input logic [1:0] h, input logic l, input logic w,
                      input logic [63:0] a, input logic [31:0] c,
                      input logic [63:0] n, input logic [63:0] r,
                      input string tag);
    exec = e; bo = o; bi = s; bh = h; lk = l; wide_mode = w;
    cia = a; cr = c; ctr_in = n; lr_in = r;
    model();
    @(negedge clk);
    chk(tag, "nia", nia_q, e_nia);
    chk(tag, "ctr", ctr_q, e_ctr);
    chk(tag, "lr",  lr_q,  e_lr);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "nia", nia_q, 64'h0);
    chk("R1", "ctr", ctr_q, 64'h0);
    chk("R1", "lr",  lr_q,  64'h0);

    // Load a nonzero state, then R2: no strobe keeps it
    step(1, 5'b10100, 0, 0, 1, 1, 64'h1000, 0, 64'h55, 64'h2003, "R7 R8");
    step(0, 5'b00000, 3, 3, 1, 0, 64'hdead, '1, 64'h9, 64'h7777, "R2");
    step(0, 5'b10000, 9, 1, 0, 1, 64'hbeef, 0, 64'h0, 64'h0, "R2");

    // R3 decrement, count nonzero, condition bypassed -> taken
    step(1, 5'b10000, 0, 0, 0, 1, 64'h2000, 0, 64'd5, 64'h4007, "R3 R7");
    // R3 no decrement when bo[2] set
    step(1, 5'b10100, 0, 0, 0, 1, 64'h2000, 0, 64'd5, 64'h4007, "R3");
    // R4 count reaches zero, no inversion -> fall through
    step(1, 5'b10000, 0, 0, 0, 1, 64'h3000, 0, 64'd1, 64'h5000, "R4");
    // R4 count reaches zero, inverted -> taken
    step(1, 5'b10010, 0, 0, 0, 1, 64'h3000, 0, 64'd1, 64'h5000, "R4");
    // R4 decrement wraps from zero -> nonzero
    step(1, 5'b10000, 0, 0, 0, 1, 64'h3100, 0, 64'd0, 64'h5100, "R4 R3");
    // R5 low word zero after decrement: wide passes, narrow fails
    step(1, 5'b10000, 0, 0, 0, 1, 64'h4000, 0, 64'h1_0000_0001, 64'h6000, "R5");
    step(1, 5'b10000, 0, 0, 0, 0, 64'h4000, 0, 64'h1_0000_0001, 64'h6000, "R5");
    step(1, 5'b10010, 0, 0, 0, 0, 64'h4000, 0, 64'h1_0000_0001, 64'h6000, "R5");
    // R6 condition bit at bi=0 (cr[31]) and bi=31 (cr[0])
    step(1, 5'b00100, 0, 0, 0, 1, 64'h5000, 32'h8000_0000, 64'd2, 64'h7000, "R6");
    step(1, 5'b01100, 0, 0, 0, 1, 64'h5000, 32'h8000_0000, 64'd2, 64'h7000, "R6");
    step(1, 5'b00100, 31, 0, 0, 1, 64'h5000, 32'h0000_0001, 64'd2, 64'h7000, "R6");
    step(1, 5'b01100, 31, 0, 0, 1, 64'h5000, 32'h0000_0001, 64'd2, 64'h7000, "R6");
    step(1, 5'b00100, 16, 0, 0, 1, 64'h5000, 32'h0000_8000, 64'd2, 64'h7000, "R6");
    // R8 link written when not taken
    step(1, 5'b00100, 0, 0, 1, 1, 64'h6000, 32'h8000_0000, 64'd2, 64'h8003, "R8");
    // R9 taken with link: target from old link value
    step(1, 5'b10100, 0, 0, 1, 1, 64'h6100, 0, 64'd2, 64'h9002, "R9");
    // R10 hint values produce identical results
    for (int h = 0; h < 4; h++)
      step(1, 5'b00000, 7, 2'(h), 1, 0, 64'h7000, 32'h0100_0000, 64'h2, 64'ha00f, "R10");

    // Mixed patterns, model compared every clock
    for (int i = 0; i < 400; i++) begin
      logic [63:0] n;
      n = (i % 3 == 0) ? 64'($urandom_range(0, 3)) :
          (i % 3 == 1) ? {32'($urandom_range(0, 1)), 32'($urandom_range(0, 2))} :
                         {$urandom, $urandom};
      step(1'($urandom_range(0, 4) != 0), 5'($urandom), 5'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), {$urandom, $urandom}, $urandom, n,
           {$urandom, $urandom}, "R4 R5 R6 R7 R8");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule